// File: doc/BRIEF.md
# Vernier Coarse Interval Quantizer

This block measures the time between a start strobe and a stop strobe by racing two tokens down two parallel delay chains. The start token moves through a slow chain of stages that each hold it 3 clock cycles. The stop token moves through a fast chain of stages that each hold it 2 cycles. The stop token therefore gains one cycle at every stage. At each stage an arbiter decides whether the start token is still ahead there. The arbiters that answer yes form a thermometer word, and counting its ones gives a binary coarse code. One stage resolves one cycle of start-to-stop difference, so an interval of d cycles yields code d, up to a saturated full scale.

Each strobe is captured into a held level before it enters its chain. An arm control clears the capture levels, the chains, the arbiters and the done flag, and opens a new measurement window. A measurement finishes when the stop token catches the start token at some stage, or when the last stage has been decided. The done flag then rises, and the word and the code stay frozen until the next arm.

Top module: `vernier_quantizer`

## Requirements
- R1: After reset, or on the clock edge that samples arm_i high, therm_o is 0, code_o is 0 and done_o is 0. Strobes sampled in that same cycle are ignored. No token left over from a cleared window later sets a bit.
- R2: If a stop strobe is sampled d cycles after the start strobe, with 1 <= d <= 14, the final code_o is d and therm_o has bits 0 to d-1 set and all other bits clear. Bit i means "start was ahead at stage i".
- R3: A start strobe and a stop strobe sampled in the same cycle give code_o 0, therm_o 0 and done_o 1.
- R4: An interval of 15 cycles or more, or a start with no stop at all, saturates the result: code_o is 15 and therm_o is all ones.
- R5: If the start strobe is sampled at edge n, done_o first reads high after edge n + 3*min(d,14) + 1. With no stop, d counts as 15.
- R6: A stop strobe that arrives before any start in the window is ignored. No bit is set and done_o stays low. A later start is then measured against the next stop only.
- R7: Only the first start strobe and the first accepted stop strobe in a window count. Later strobes do not change the result.
- R8: Once done_o is high, done_o, therm_o and code_o stay constant until arm_i, whatever strobes arrive.
- R9: therm_o is always a contiguous run of ones from bit 0, and code_o always equals the number of ones in therm_o.
- R10: Stage i is decided 3*i + 1 cycles after the start edge. While the start is still ahead, the count of set bits grows by one every 3 cycles, and each stage's token is never present unless the stage before it already holds one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arm_i | input | 1 | Clears all state and opens a new measurement window |
| start_i | input | 1 | Single-cycle start strobe |
| stop_i | input | 1 | Single-cycle stop strobe |
| therm_o | output | 15 | Arbiter outputs; bit i set when start led at stage i |
| code_o | output | 4 | Binary coarse code, the number of ones in therm_o |
| done_o | output | 1 | Measurement complete; held until the next arm |

## Verification
The assertions check the following on every cycle:
- the shape of the thermometer word and its agreement with the code;
- the ordering of tokens along each chain;
- that no arbiter is set before the start token reaches its stage;
- that the results stay frozen after done;
- that an arm clears the block.

Only the bench's scenarios can show that the code matches the start-to-stop interval, how the result saturates, the exact cycle in which done rises, and the stage-by-stage growth of the word. The bench also covers ignored stray strobes and the absence of leftover tokens after an arm in mid-measurement. It sweeps every interval from 0 to 20 cycles, and the case with no stop.

// File: rtl/vq_pkg.sv
package vq_pkg;

  typedef enum logic [1:0] {
    VQ_IDLE = 2'd0,
    VQ_RUN  = 2'd1,
    VQ_DONE = 2'd2
  } vq_phase_e;

  // Index in a chain's shift register that holds the token for a given stage
  function automatic int vq_tap_index(input int stage, input int dly);
    return stage * dly - 1;
  endfunction

  // Width of a binary count that can reach 'stages'
  function automatic int vq_code_width(input int stages);
    return $clog2(stages + 1);
  endfunction

endpackage

// File: rtl/vq_capture.sv
module vq_capture (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic done_i,
  input  logic start_i,
  input  logic stop_i,
  output logic start_lvl_o,
  output logic stop_lvl_o,
  output logic start_acc_o
);

  logic stop_acc;

  // A start counts only once per window and never after completion
  assign start_acc_o = start_i & ~start_lvl_o & ~done_i & ~clr_i;
  // A stop counts only when a start is held or is being taken this cycle
  assign stop_acc    = stop_i & ~stop_lvl_o & ~done_i & ~clr_i &
                       (start_lvl_o | start_acc_o);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      start_lvl_o <= 1'b0;
      stop_lvl_o  <= 1'b0;
    end else begin
      if (start_acc_o) start_lvl_o <= 1'b1;
      if (stop_acc)    stop_lvl_o  <= 1'b1;
    end
  end

  // R6: the stop level is never held without the start level
  a_r6_stop_needs_start: assert property (@(posedge clk) disable iff (rst)
    stop_lvl_o |-> start_lvl_o);

endmodule

// File: rtl/vq_chain.sv
module vq_chain #(
  parameter int STAGES = 15,
  parameter int DLY    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              lvl_i,
  output logic [STAGES-1:0] tap_o
);
  import vq_pkg::*;

  localparam int LEN = (STAGES - 1) * DLY;

  logic [LEN-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      sr <= '0;
    end else begin
      sr[0] <= lvl_i;
      for (int k = 1; k < LEN; k++) sr[k] <= sr[k-1];
    end
  end

  assign tap_o[0] = lvl_i;

  for (genvar i = 1; i < STAGES; i++) begin : g_tap
    assign tap_o[i] = sr[vq_tap_index(i, DLY)];

    // R10: a token reaches a stage only after it has reached the one before
    a_r10_tap_order: assert property (@(posedge clk) disable iff (rst)
      tap_o[i] |-> tap_o[i-1]);
  end

endmodule

// File: rtl/vq_arbiters.sv
module vq_arbiters #(
  parameter int STAGES = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              freeze_i,
  input  logic [STAGES-1:0] tap_start_i,
  input  logic [STAGES-1:0] tap_stop_i,
  output logic [STAGES-1:0] q_o,
  output logic              catch_o,
  output logic              last_o
);

  logic [STAGES-1:0] decided;
  logic [STAGES-1:0] eval_now;

  // A stage is decided once, on the first cycle the start token is present
  assign eval_now = tap_start_i & ~decided & {STAGES{~freeze_i}};
  assign catch_o  = |(eval_now & tap_stop_i);
  assign last_o   = eval_now[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      decided <= '0;
      q_o     <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) begin
        if (eval_now[i]) begin
          decided[i] <= 1'b1;
          q_o[i]     <= ~tap_stop_i[i];
        end
      end
    end
  end

  for (genvar i = 0; i < STAGES; i++) begin : g_chk
    // R2: an arbiter set means the start token has reached its stage
    a_r2_arb_after_start: assert property (@(posedge clk) disable iff (rst)
      q_o[i] |-> tap_start_i[i]);
  end

endmodule

// File: rtl/vq_encoder.sv
module vq_encoder #(
  parameter int STAGES = 15,
  parameter int CW     = 4
) (
  input  logic [STAGES-1:0] therm_i,
  output logic [CW-1:0]     code_o
);

  // Counting ones tolerates a bubble in the word
  always_comb begin
    code_o = '0;
    for (int i = 0; i < STAGES; i++) code_o = code_o + CW'(therm_i[i]);
  end

endmodule

// File: rtl/vernier_quantizer.sv
module vernier_quantizer #(
  parameter int STAGES   = 15,
  parameter int SLOW_DLY = 3,
  parameter int FAST_DLY = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         arm_i,
  input  logic                         start_i,
  input  logic                         stop_i,
  output logic [STAGES-1:0]            therm_o,
  output logic [$clog2(STAGES+1)-1:0]  code_o,
  output logic                         done_o
);
  import vq_pkg::*;

  localparam int CW = vq_code_width(STAGES);

  vq_phase_e         phase;
  logic              start_lvl, stop_lvl, start_acc;
  logic [STAGES-1:0] tap_start, tap_stop;
  logic              catch_ev, last_ev, finish_ev;

  assign done_o    = (phase == VQ_DONE);
  assign finish_ev = catch_ev | last_ev;

  vq_capture u_capture (
    .clk         (clk),
    .rst         (rst),
    .clr_i       (arm_i),
    .done_i      (done_o),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .start_lvl_o (start_lvl),
    .stop_lvl_o  (stop_lvl),
    .start_acc_o (start_acc)
  );

  vq_chain #(.STAGES(STAGES), .DLY(SLOW_DLY)) u_slow (
    .clk   (clk),
    .rst   (rst),
    .clr_i (arm_i),
    .lvl_i (start_lvl),
    .tap_o (tap_start)
  );

  vq_chain #(.STAGES(STAGES), .DLY(FAST_DLY)) u_fast (
    .clk   (clk),
    .rst   (rst),
    .clr_i (arm_i),
    .lvl_i (stop_lvl),
    .tap_o (tap_stop)
  );

  vq_arbiters #(.STAGES(STAGES)) u_arb (
    .clk         (clk),
    .rst         (rst),
    .clr_i       (arm_i),
    .freeze_i    (done_o),
    .tap_start_i (tap_start),
    .tap_stop_i  (tap_stop),
    .q_o         (therm_o),
    .catch_o     (catch_ev),
    .last_o      (last_ev)
  );

  vq_encoder #(.STAGES(STAGES), .CW(CW)) u_enc (
    .therm_i (therm_o),
    .code_o  (code_o)
  );

  always_ff @(posedge clk) begin
    if (rst || arm_i) begin
      phase <= VQ_IDLE;
    end else begin
      case (phase)
        VQ_IDLE: if (start_acc) phase <= VQ_RUN;
        VQ_RUN:  if (finish_ev) phase <= VQ_DONE;
        default: phase <= phase;
      endcase
    end
  end

  // R1: an arm clears the word and the done flag on the next edge
  a_r1_arm_clears: assert property (@(posedge clk) disable iff (rst)
    arm_i |=> (therm_o == '0 && !done_o));

  // R6: without an accepted start no arbiter is set
  a_r6_idle_no_bits: assert property (@(posedge clk) disable iff (rst)
    (phase == VQ_IDLE) |-> (therm_o == '0 && !stop_lvl));

  // R8: done holds until the next arm
  a_r8_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done_o && !arm_i) |=> done_o);

  // R8: the word is frozen while done
  a_r8_therm_frozen: assert property (@(posedge clk) disable iff (rst)
    (done_o && !arm_i) |=> $stable(therm_o));

  // R9: contiguous ones from bit 0
  a_r9_therm_shape: assert property (@(posedge clk) disable iff (rst)
    (therm_o & (therm_o + 1'b1)) == '0);

  // R9: the code counts the ones in the word
  a_r9_code_count: assert property (@(posedge clk) disable iff (rst)
    int'(code_o) == $countones(therm_o));

endmodule

// File: tb/vernier_quantizer_tb_top.sv
module vernier_quantizer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NST = 15;

  logic clk = 1'b0;
  logic rst, arm_i, start_i, stop_i;
  logic [NST-1:0] therm_o;
  logic [3:0] code_o;
  logic done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vernier_quantizer dut_i (
    .clk(clk), .rst(rst), .arm_i(arm_i), .start_i(start_i), .stop_i(stop_i),
    .therm_o(therm_o), .code_o(code_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_arm();
    @(negedge clk); arm_i = 1'b1;
    @(negedge clk); arm_i = 1'b0;
  endtask

  // Interval d (stop sampled d edges after start); has_stop=0 means no stop
  task automatic measure(input int d, input bit has_stop);
    int dc, t_done, exp_code, first_done, good_prog;
    string req;
    dc = has_stop ? d : 99;
    t_done = 3 * ((dc < 14) ? dc : 14) + 1;
    exp_code = (dc < 15) ? dc : 15;
    first_done = -1;
    good_prog = 1;
    do_arm();
    for (int j = 0; j <= t_done + 4; j++) begin
      int cnt;
      cnt = 0;
      for (int i = 0; i < NST; i++)
        if (i < dc && 3 * i + 2 <= j) cnt++;
      if (int'(code_o) != cnt) good_prog = 0;
      if (done_o && first_done < 0) first_done = j;
      start_i = (j == 0);
      stop_i  = has_stop && (j == d);
      @(negedge clk);
    end
    start_i = 1'b0; stop_i = 1'b0;
    req = (dc == 0) ? "R3" : ((dc >= 15) ? "R4" : "R2");
    chk(int'(code_o) == exp_code, req, $sformatf("code d=%0d", d),
        int'(code_o), exp_code);
    chk(int'(therm_o) == ((1 << exp_code) - 1), req, $sformatf("therm d=%0d", d),
        int'(therm_o), (1 << exp_code) - 1);
    chk(first_done == t_done + 1, "R5", $sformatf("done cycle d=%0d", d),
        first_done, t_done + 1);
    chk(good_prog == 1, "R10", $sformatf("stage progress d=%0d", d),
        good_prog, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; arm_i = 1'b0; start_i = 1'b0; stop_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(therm_o == '0 && code_o == '0 && !done_o, "R1", "reset state",
        int'(therm_o) + int'(done_o), 0);
    rst = 1'b0;

    // Sweep of intervals, R2 R3 R4 R5 R10
    for (int d = 0; d <= 20; d++) measure(d, 1'b1);
    measure(0, 1'b0);

    // R6: stop alone is ignored, then start measured against a later stop
    do_arm();
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    repeat (60) @(negedge clk);
    chk(therm_o == '0 && !done_o, "R6", "stop without start",
        int'(therm_o) + int'(done_o), 0);
    for (int j = 0; j <= 20; j++) begin
      start_i = (j == 0); stop_i = (j == 4);
      @(negedge clk);
    end
    start_i = 1'b0; stop_i = 1'b0;
    chk(code_o == 4'd4 && done_o, "R6", "start after ignored stop",
        int'(code_o), 4);

    // R7: repeated strobes within a window
    do_arm();
    for (int j = 0; j <= 30; j++) begin
      start_i = (j == 0 || j == 2); stop_i = (j == 5 || j == 7);
      @(negedge clk);
    end
    start_i = 1'b0; stop_i = 1'b0;
    chk(code_o == 4'd5 && done_o, "R7", "first strobes only", int'(code_o), 5);

    // R8: strobes after done change nothing
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (3) @(negedge clk);
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    repeat (60) @(negedge clk);
    chk(code_o == 4'd5 && therm_o == 15'h1f && done_o, "R8", "held after done",
        int'(code_o), 5);

    // R1: arm during a measurement clears and leaves no stale token
    do_arm();
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (10) @(negedge clk);
    arm_i = 1'b1; start_i = 1'b1; @(negedge clk); arm_i = 1'b0; start_i = 1'b0;
    chk(therm_o == '0 && !done_o, "R1", "arm mid measurement",
        int'(therm_o), 0);
    repeat (60) @(negedge clk);
    chk(therm_o == '0 && !done_o, "R1", "no stale token after arm",
        int'(therm_o) + int'(done_o), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule